// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Bank

This block holds the configuration of a bank of general-purpose pins and produces, for each pin, a drive enable, a drive level and a weak pull-up enable for the pad cell. Software configures each pin through two bit-per-pin registers: a direction register and a port register. The port register sets the drive level of an output pin or requests the pull-up of an input pin. One global bit in a control register turns off every pull-up at once.

The raw pad levels return through a two-stage synchronizer before they are visible in a read-only pin register. The first stage samples on the falling clock edge and the second on the rising edge. A pad change therefore reaches the pin register between half a cycle and one and a half cycles later. The pin register always shows the pad level, whatever the pin's direction, so an output pin can be read back from its pad.

Top module: `gpio_bank`

## Requirements
- R1: After a clock edge with `rst_n` low, the direction register, the port register and the pull-up disable bit are all 0. All `pad_oe`, `pad_out` and `pad_pu` bits are 0, and the pin register reads 0 once the synchronizer has been reset on both edges.
- R2: A pin with direction 0 and port 0 has `pad_oe`=0 and `pad_pu`=0, whatever the value of the pull-up disable bit.
- R3: A pin with direction 0 and port 1 has `pad_oe`=0, and its `pad_pu` is the inverse of the pull-up disable bit.
- R4: A pin with direction 1 has `pad_oe`=1, `pad_out` equal to its port bit and `pad_pu`=0, whatever the value of the pull-up disable bit. A pin with direction 0 has `pad_out`=0.
- R5: When `wr_en` is high at a rising edge, `wr_data` is stored as follows. Select 0 writes the direction register, select 1 writes the port register, and select 3 writes bit 0 of `wr_data` into the pull-up disable bit. `rd_data` shows the selected register combinationally. Select 3 reads as seven zero bits above the disable bit.
- R6: A write with select 2 (the pin register) changes no register and no pad-side output.
- R7: Select 2 reads the synchronized pad levels of all pins, whatever their direction. This includes the level of a pin that is driving its own pad.
- R8: The pad level is sampled at a falling edge and reaches the pin register at the following rising edge. A change just before a falling edge therefore appears about half a cycle later, and a change just after a falling edge appears about one and a half cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| reg_sel | input | 2 | Register select: 0 direction, 1 port, 2 pin, 3 control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| pad_in | input | 8 | Raw pad levels (asynchronous) |
| pad_oe | output | 8 | Per-pin drive enable |
| pad_out | output | 8 | Per-pin drive level |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The bench builds the block with its default width of eight pins. Every random write therefore sets all eight pins at once, and all four combinations of direction and port, with both values of the pull-up disable bit, are reached within a few hundred cycles. Pad levels change a little after each rising edge, so the one-cycle path through the synchronizer is checked on every cycle. Directed timing cases place a pad change just before and just after a falling edge to reach both the shortest and the longest delay. A loopback case feeds `pad_out` back into `pad_in` to read back output pins.

// File: rtl/gpio_pkg.sv
// gpio_pkg: register select codes shared by the GPIO bank modules.
// Assumes a two-bit select field on the register bus.
package gpio_pkg;
    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_PORT = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_CTRL = 2'd3
    } gpio_sel_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
// gpio_cfg_regs: holds the direction register, the port register and the
// global pull-up disable bit. Writes commit on the rising edge.
// Assumes a synchronous active-low reset. A write to the pin select is dropped here.
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       reg_sel,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] port_q,
    output logic             pud_q
);
    // Register update from the bus write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            port_q <= '0;
            pud_q  <= 1'b0;
        end else if (wr_en) begin
            if (reg_sel == SEL_DIR)  dir_q  <= wr_data;
            if (reg_sel == SEL_PORT) port_q <= wr_data;
            if (reg_sel == SEL_CTRL) pud_q  <= wr_data[0];
        end
    end

    // R5
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_DIR) |=> dir_q == $past(wr_data));
    // R6
    pin_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_PIN) |=> ($stable(dir_q) && $stable(port_q) && $stable(pud_q)));
endmodule

// File: rtl/gpio_pin_ctl.sv
// gpio_pin_ctl: per-pin decode of direction, port and the global pull-up
// disable into drive enable, drive level and pull-up enable.
// Assumes purely combinational use. One generate slice per pin.
module gpio_pin_ctl #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] port_q,
    input  logic             pud_q,
    output logic [NPINS-1:0] oe,
    output logic [NPINS-1:0] drv,
    output logic [NPINS-1:0] pu
);
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        // Decode of one pin's mode.
        always_comb begin
            oe[g]  = dir_q[g];
            drv[g] = dir_q[g] & port_q[g];
            pu[g]  = ~dir_q[g] & port_q[g] & ~pud_q;
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
// gpio_in_sync: two-stage synchronizer for the pad levels. The first stage
// samples on the falling edge and the second on the rising edge.
// Assumes the pads are asynchronous. Both stages reset synchronously to 0.
module gpio_in_sync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pin_q
);
    logic [NPINS-1:0] half_q;

    // Falling-edge capture stage.
    always_ff @(negedge clk) begin
        if (!rst_n) half_q <= '0;
        else        half_q <= pad_in;
    end

    // Rising-edge transfer into the pin register.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= half_q;
    end
endmodule

// File: rtl/gpio_bank.sv
// gpio_bank: top level of the GPIO bank. It ties together the configuration
// registers, the per-pin decode, the input synchronizer and the readback mux.
// Assumes reads are combinational on reg_sel. The width is set by NPINS.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       reg_sel,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] rd_data,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_pu
);
    localparam int CTRL_PAD = NPINS - 1;

    logic [NPINS-1:0] dir_q, port_q, pin_q;
    logic             pud_q;

    gpio_cfg_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .dir_q(dir_q), .port_q(port_q), .pud_q(pud_q)
    );

    gpio_pin_ctl #(.NPINS(NPINS)) u_ctl (
        .dir_q(dir_q), .port_q(port_q), .pud_q(pud_q),
        .oe(pad_oe), .drv(pad_out), .pu(pad_pu)
    );

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pin_q(pin_q)
    );

    // Readback mux over the four registers.
    always_comb begin
        case (reg_sel)
            SEL_DIR:  rd_data = dir_q;
            SEL_PORT: rd_data = port_q;
            SEL_PIN:  rd_data = pin_q;
            default:  rd_data = {{CTRL_PAD{1'b0}}, pud_q};
        endcase
    end

    // R3
    pud_kills_pullups_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_CTRL && wr_data[0]) |=> pad_pu == '0);
    // R4
    port_write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_PORT) |=> pad_out == ($past(wr_data) & pad_oe));
    // R4
    no_drive_with_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0);
    // R6
    pin_write_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_PIN) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));
endmodule

// File: tb/gpio_bank_bench.sv
`timescale 1ns/100ps
module gpio_bank_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   reg_sel = 2'd0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] rd_data, pad_oe, pad_out, pad_pu;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state
    logic [N-1:0] m_dir = '0, m_port = '0, m_pin = '0;
    logic         m_pud = 1'b0;

    always #2 clk = ~clk;

    gpio_bank #(.NPINS(N)) u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    function automatic logic [N-1:0] exp_pu(logic [N-1:0] d, logic [N-1:0] p, logic u);
        return ~d & p & {N{~u}};
    endfunction

    function automatic logic [N-1:0] exp_rd(logic [1:0] s);
        case (s)
            2'd0:    return m_dir;
            2'd1:    return m_port;
            2'd2:    return m_pin;
            default: return {{(N-1){1'b0}}, m_pud};
        endcase
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_pads(string req);
        check({req, " oe"},  pad_oe,  m_dir);
        check({req, " out"}, pad_out, m_dir & m_port);
        check({req, " pu"},  pad_pu,  exp_pu(m_dir, m_port, m_pud));
    endtask

    // one bus write, committed at the next rising edge; model updated after it
    task automatic bus_write(logic [1:0] s, logic [N-1:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; reg_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        case (s)
            2'd0: m_dir = d;
            2'd1: m_port = d;
            2'd3: m_pud = d[0];
            default: ;
        endcase
    endtask

    task automatic read_chk(string req, logic [1:0] s);
        reg_sel = s; #0.5;
        check(req, rd_data, exp_rd(s));
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check_pads("R1 reset");
        for (int s = 0; s < 4; s++) read_chk("R1 reset read", s[1:0]);
        rst_n = 1'b1;

        // R2/R3/R4 directed: all four modes, both pud values
        bus_write(2'd0, 8'b1100_1100);
        bus_write(2'd1, 8'b1010_1010);
        check_pads("R2 R3 R4 pud0");
        check("R3 pullup on", pad_pu, 8'b0010_0010);
        check("R2 hiz", pad_pu & 8'b0001_0001, '0);
        bus_write(2'd3, 8'hFF);
        check_pads("R2 R3 R4 pud1");
        check("R3 pullup off", pad_pu, '0);
        check("R4 drive", pad_out, 8'b1000_1000);
        read_chk("R5 ctrl read", 2'd3);
        bus_write(2'd3, 8'h00);

        // R6: pin register write is ignored
        bus_write(2'd2, 8'h5A);
        check_pads("R6 pin write");
        for (int s = 0; s < 4; s++) read_chk("R6 regs unchanged", s[1:0]);

        // R8 shortest: change just before falling edge, visible after next rise
        @(posedge clk); #1.8; pad_in = 8'hA5;
        @(posedge clk); #1; m_pin = 8'hA5;
        read_chk("R8 min latency", 2'd2);
        // R8 longest: change just after falling edge
        @(negedge clk); #0.3; pad_in = 8'h3C;
        @(posedge clk); #1;
        read_chk("R8 max not yet", 2'd2);
        @(posedge clk); #1; m_pin = 8'h3C;
        read_chk("R8 max latency", 2'd2);

        // R7: loopback of outputs through the pads
        bus_write(2'd0, 8'hF0);
        bus_write(2'd1, 8'h96);
        pad_in = pad_out;
        repeat (2) @(posedge clk);
        #1; m_pin = m_dir & m_port;
        read_chk("R7 output readback", 2'd2);

        // R5/R7/R8 random: one op per cycle, pad changes after each rise
        for (int i = 0; i < 3000; i++) begin
            logic [1:0]   s;
            logic [N-1:0] d;
            logic [N-1:0] pv;
            logic         w;
            s = 2'($urandom_range(0, 3));
            d = N'($urandom);
            w = ($urandom_range(0, 2) != 0);
            pv = N'($urandom);
            @(posedge clk); #1;
            wr_en = w; reg_sel = s; wr_data = d; pad_in = pv;
            @(posedge clk); #1;
            wr_en = 1'b0;
            if (w) begin
                case (s)
                    2'd0: m_dir = d;
                    2'd1: m_port = d;
                    2'd3: m_pud = d[0];
                    default: ;
                endcase
            end
            m_pin = pv;
            check_pads("R2 R3 R4 random");
            read_chk("R5 R7 random read", 2'($urandom_range(0, 3)));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule